// File: doc/BRIEF.md
# Pseudo-Static RAM Row Address Sequencer

This block models, cycle by cycle, how a pseudo-static RAM chooses the row it opens. All pins are sampled on the system clock. A falling chip enable captures the external address. The low eight address bits name one of 256 rows, and the upper seven bits name the column. At that same edge the strobe levels decide whether the cycle is a read, a write, or a refresh of the addressed row alone.

While chip enable is high, a falling edge on the shared lower-output-enable/refresh pin starts an auto-refresh. That row comes from an internal 8-bit refresh counter, which steps once per auto-refresh. One register-fed multiplexer supplies the selected row from either the latched external row or the counter. The block is intended as a synthesizable device-side model for checking a memory controller.

Top module: `psram_row_sequencer`

## Requirements
- R1: After reset, `cycle_kind` reads 0 (standby), `row_sel` is 0, `row_act`, `col_valid`, `bus_drive` and `proto_err` are 0, and the refresh counter holds 0.
- R2: In the clock cycle after chip enable is first seen low, `row_sel` equals address bits 7..0 and `row_act` is high for exactly that one cycle.
- R3: The cycle is classified at the chip-enable fall. Either write strobe low gives write (code 2). Otherwise either output enable low gives read (code 1). Otherwise the cycle is a chip-enable-only refresh (code 3). A cycle's kind does not change while chip enable stays low.
- R4: A chip-enable-only refresh opens the external row, ignores address bits 14..8 (`col_valid` stays 0), keeps `bus_drive` low, and leaves the refresh counter unchanged.
- R5: A falling edge on the refresh pin while chip enable is high and was high in the previous sample starts an auto-refresh (code 4). `row_sel` takes the counter value with a one-cycle `row_act`, and the address and write inputs have no effect.
- R6: The refresh counter increments by one after each auto-refresh and wraps from 255 to 0.
- R7: `bus_drive` is high only in a read cycle with chip enable low and at least one output enable low. It stays low in both refresh kinds and in standby.
- R8: A rising chip enable returns the kind to standby (code 0). So does the refresh pin rising during an auto-refresh. `row_sel` holds its last value.
- R9: If the refresh pin is low in the sample where chip enable rises, `proto_err` pulses for one cycle and no auto-refresh starts. That includes a pin fall in that same sample. A fresh falling edge is needed before a refresh runs.
- R10: `col_valid` is high exactly while the kind is read or write.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en_n | input | 1 | Chip enable, active low |
| oe_lo_ref_n | input | 1 | Lower-byte output enable while chip enable is low; refresh request while it is high |
| oe_hi_n | input | 1 | Upper-byte output enable, active low |
| we_lo_n | input | 1 | Lower-byte write strobe, active low |
| we_hi_n | input | 1 | Upper-byte write strobe, active low |
| ext_addr | input | 15 | External address: bits 7..0 row, bits 14..8 column |
| row_sel | output | 8 | Row currently selected by the multiplexer |
| row_act | output | 1 | One-cycle row activation pulse |
| col_valid | output | 1 | Column address in use (read or write) |
| cycle_kind | output | 3 | 0 standby, 1 read, 2 write, 3 chip-enable-only refresh, 4 auto-refresh |
| bus_drive | output | 1 | Data bus would be driven |
| proto_err | output | 1 | Refresh pin low when chip enable returned high |

## Verification
Two functions can meet in one sampled cycle: chip enable rising to end an access, and the refresh pin falling to request an auto-refresh. The bench provokes this by raising chip enable and dropping the refresh pin in the same driven step. It also holds the pin low across a read's end. The bench expects a protocol-error pulse and standby, with no row activation. It then issues a later clean refresh and checks that the counter did not advance.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [2:0] {
    KIND_IDLE   = 3'd0,
    KIND_READ   = 3'd1,
    KIND_WRITE  = 3'd2,
    KIND_ROWREF = 3'd3,
    KIND_AUTO   = 3'd4
  } cyc_kind_e;

  // Decide the access kind from strobe levels seen at the chip-enable fall.
  function automatic cyc_kind_e classify(input logic we_lo_n, input logic we_hi_n,
                                         input logic oe_lo_n, input logic oe_hi_n);
    if (!we_lo_n || !we_hi_n)      return KIND_WRITE;
    else if (!oe_lo_n || !oe_hi_n) return KIND_READ;
    else                           return KIND_ROWREF;
  endfunction

  function automatic logic uses_column(input cyc_kind_e k);
    return (k == KIND_READ) || (k == KIND_WRITE);
  endfunction

endpackage

// File: rtl/psr_edge_detect.sv
module psr_edge_detect #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] prev_n,
  output logic [N-1:0] fell,
  output logic [N-1:0] rose
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_n[i] <= 1'b1;
      else        prev_n[i] <= pin_n[i];
    end
    assign fell[i] = prev_n[i] & ~pin_n[i];
    assign rose[i] = ~prev_n[i] & pin_n[i];
  end
endmodule

// File: rtl/psr_refresh_ctr.sv
module psr_refresh_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         advance,
  output logic [W-1:0] count
);
  function automatic logic [W-1:0] step_wrap(input logic [W-1:0] v);
    return v + {{(W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (advance) count <= step_wrap(count);
  end

  // R6: one advance moves the counter by exactly one, modulo 2^W
  a_r6_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> count == $past(count) + 1'b1);
  a_r6_ctr_still: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(count));
endmodule

// File: rtl/psr_row_mux.sv
module psr_row_mux #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_ext,
  input  logic         take_ctr,
  input  logic [W-1:0] ext_row,
  input  logic [W-1:0] ctr_row,
  output logic [W-1:0] row_q,
  output logic         act_q
);
  logic [W-1:0] pick;
  assign pick = take_ctr ? ctr_row : ext_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      act_q <= 1'b0;
    end else begin
      act_q <= take_ext | take_ctr;
      if (take_ext || take_ctr) row_q <= pick;
    end
  end

  // R5/R2: the two sources are never requested together
  a_r5_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_ext && take_ctr));
  // R8: the row holds when nothing is loaded
  a_r8_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_ext || take_ctr) |=> $stable(row_q));
endmodule

// File: rtl/psram_row_sequencer.sv
module psram_row_sequencer
  import psr_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chip_en_n,
  input  logic                   oe_lo_ref_n,
  input  logic                   oe_hi_n,
  input  logic                   we_lo_n,
  input  logic                   we_hi_n,
  input  logic [ROW_W+COL_W-1:0] ext_addr,
  output logic [ROW_W-1:0]       row_sel,
  output logic                   row_act,
  output logic                   col_valid,
  output logic [2:0]             cycle_kind,
  output logic                   bus_drive,
  output logic                   proto_err
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int CE_B   = 1;
  localparam int RF_B   = 0;

  logic [1:0] pins_n, prev_n, fell, rose;
  assign pins_n = {chip_en_n, oe_lo_ref_n};

  psr_edge_detect #(.N(2)) u_edges (
    .clk(clk), .rst_n(rst_n), .pin_n(pins_n),
    .prev_n(prev_n), .fell(fell), .rose(rose)
  );

  // Named internal events
  logic ce_fall, ce_rise, auto_start, late_req;
  assign ce_fall    = fell[CE_B];
  assign ce_rise    = rose[CE_B];
  assign auto_start = fell[RF_B] & chip_en_n & prev_n[CE_B];
  assign late_req   = ce_rise & ~oe_lo_ref_n;

  logic [ROW_W-1:0] ref_count;
  psr_refresh_ctr #(.W(ROW_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .advance(auto_start), .count(ref_count)
  );

  psr_row_mux #(.W(ROW_W)) u_mux (
    .clk(clk), .rst_n(rst_n),
    .take_ext(ce_fall), .take_ctr(auto_start),
    .ext_row(ext_addr[ROW_W-1:0]), .ctr_row(ref_count),
    .row_q(row_sel), .act_q(row_act)
  );

  cyc_kind_e kind_q, kind_d;
  always_comb begin
    kind_d = kind_q;
    if (ce_fall)                                 kind_d = classify(we_lo_n, we_hi_n, oe_lo_ref_n, oe_hi_n);
    else if (ce_rise)                            kind_d = KIND_IDLE;
    else if (auto_start)                         kind_d = KIND_AUTO;
    else if (kind_q == KIND_AUTO && oe_lo_ref_n) kind_d = KIND_IDLE;
  end

  logic err_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KIND_IDLE;
      err_q  <= 1'b0;
    end else begin
      kind_q <= kind_d;
      err_q  <= late_req;
    end
  end

  assign cycle_kind = kind_q;
  assign col_valid  = uses_column(kind_q);
  assign bus_drive  = (kind_q == KIND_READ) & ~chip_en_n & (~oe_lo_ref_n | ~oe_hi_n);
  assign proto_err  = err_q;

  // R7: no bus drive outside a read
  a_r7_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q != KIND_READ) |-> !bus_drive);
  // R2: every activation belongs to a live cycle
  a_r2_act_live: assert property (@(posedge clk) disable iff (!rst_n)
    row_act |-> kind_q != KIND_IDLE);
  // R4: a chip-enable-only refresh leaves the counter alone
  a_r4_ctr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == KIND_ROWREF) |=> $stable(ref_count));
  // R9: a late request is flagged and lands in standby
  a_r9_err_standby: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (kind_q == KIND_IDLE && !row_act));
  // R10: column in use only while chip enable was low at the last sample
  a_r10_col_ce_low: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |-> !prev_n[CE_B]);
  // R3: the access kind stays fixed while chip enable stays low
  a_r3_kind_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!prev_n[CE_B] && !chip_en_n) |=> $stable(kind_q));
endmodule

// File: tb/psram_row_sequencer_bench.sv
module psram_row_sequencer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic ce_n = 1, rf_n = 1, oeh_n = 1, wl_n = 1, wh_n = 1;
  logic [14:0] addr = '0;
  logic [7:0] row_sel;
  logic row_act, col_valid, bus_drive, proto_err;
  logic [2:0] cycle_kind;

  psram_row_sequencer u_psram_row_sequencer (
    .clk(clk), .rst_n(rst_n), .chip_en_n(ce_n), .oe_lo_ref_n(rf_n),
    .oe_hi_n(oeh_n), .we_lo_n(wl_n), .we_hi_n(wh_n), .ext_addr(addr),
    .row_sel(row_sel), .row_act(row_act), .col_valid(col_valid),
    .cycle_kind(cycle_kind), .bus_drive(bus_drive), .proto_err(proto_err)
  );

  typedef struct packed {
    logic [2:0] kind; logic [7:0] row; logic act, colv, bus, err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // Driver: apply pins after a falling edge, queue what must appear after the next rise.
  task automatic step(input logic c, input logic r, input logic oh, input logic wl,
                      input logic wh, input logic [14:0] a, input logic [2:0] k,
                      input logic [7:0] rw, input logic ac, input logic cv,
                      input logic bd, input logic er, input string tag);
    @(negedge clk);
    ce_n = c; rf_n = r; oeh_n = oh; wl_n = wl; wh_n = wh; addr = a;
    exp_q.push_back('{kind:k, row:rw, act:ac, colv:cv, bus:bd, err:er});
    tag_q.push_back(tag);
  endtask

  // Monitor: compare one expected item per cycle.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e, g;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      g = '{kind:cycle_kind, row:row_sel, act:row_act, colv:col_valid, bus:bus_drive, err:proto_err};
      checks++;
      if (g !== e) begin
        fails++;
        $display("FAIL %s: got kind=%0d row=%02h act=%b col=%b bus=%b err=%b, expected kind=%0d row=%02h act=%b col=%b bus=%b err=%b",
                 t, g.kind, g.row, g.act, g.colv, g.bus, g.err,
                 e.kind, e.row, e.act, e.colv, e.bus, e.err);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(1,1,1,1,1,15'h0000, 0,8'h00,0,0,0,0, "R1 reset idle");
    // R2/R3 read, then hold
    step(0,0,1,1,1,15'h1234, 1,8'h34,1,1,1,0, "R2 R3 read latch");
    step(0,0,1,1,1,15'h5555, 1,8'h34,0,1,1,0, "R2 act one cycle");
    step(1,1,1,1,1,15'h0000, 0,8'h34,0,0,0,0, "R8 ce rise standby");
    // R3 write
    step(0,1,1,0,1,15'h7F5A, 2,8'h5A,1,1,0,0, "R3 R10 write");
    step(0,0,1,1,1,15'h7F5A, 2,8'h5A,0,1,0,0, "R3 kind fixed");
    step(1,1,1,1,1,15'h0000, 0,8'h5A,0,0,0,0, "R8 standby");
    // R4 chip-enable-only refresh
    step(0,1,1,1,1,15'h7F81, 3,8'h81,1,0,0,0, "R4 row refresh");
    step(0,1,0,1,1,15'h7F81, 3,8'h81,0,0,0,0, "R7 R4 no drive");
    step(1,1,1,1,1,15'h0000, 0,8'h81,0,0,0,0, "R8 standby");
    // R5 auto refresh uses counter 0 (R4 left it alone)
    step(1,0,1,0,0,15'h00AA, 4,8'h00,1,0,0,0, "R5 R4 auto row0");
    step(1,0,1,0,0,15'h00AA, 4,8'h00,0,0,0,0, "R5 auto hold");
    step(1,1,1,1,1,15'h0000, 0,8'h00,0,0,0,0, "R8 auto end");
    // R6 walk the counter through every value and wrap
    for (int k = 1; k < 256; k++) begin
      step(1,0,1,1,1,15'h0000, 4,k[7:0],1,0,0,0, "R6 auto step");
      step(1,1,1,1,1,15'h0000, 0,k[7:0],0,0,0,0, "R6 auto end");
    end
    step(1,0,1,1,1,15'h0000, 4,8'h00,1,0,0,0, "R6 wrap to 0");
    step(1,1,1,1,1,15'h0000, 0,8'h00,0,0,0,0, "R6 end");
    // R9 refresh pin held low across ce rise
    step(0,0,1,1,1,15'h2211, 1,8'h11,1,1,1,0, "R9 read before");
    step(1,0,1,1,1,15'h0000, 0,8'h11,0,0,0,1, "R9 late request");
    step(1,0,1,1,1,15'h0000, 0,8'h11,0,0,0,0, "R9 no auto");
    step(1,1,1,1,1,15'h0000, 0,8'h11,0,0,0,0, "R9 release");
    step(1,0,1,1,1,15'h0000, 4,8'h01,1,0,0,0, "R9 R6 counter kept");
    // chip enable falls during auto refresh
    step(1,1,1,1,1,15'h0000, 0,8'h01,0,0,0,0, "R8 end");
    step(1,0,1,1,1,15'h0000, 4,8'h02,1,0,0,0, "R5 auto row2");
    step(0,0,1,1,1,15'h0C3C, 1,8'h3C,1,1,1,0, "R3 read after auto");
    step(1,1,1,1,1,15'h0000, 0,8'h3C,0,0,0,0, "R8 standby");
    // R9 same-cycle: ce rises while refresh pin falls
    step(0,1,1,1,1,15'h0155, 3,8'h55,1,0,0,0, "R4 row refresh");
    step(1,0,1,1,1,15'h0000, 0,8'h55,0,0,0,1, "R9 same cycle");
    step(1,1,1,1,1,15'h0000, 0,8'h55,0,0,0,0, "R9 release");
    step(1,0,1,1,1,15'h0000, 4,8'h03,1,0,0,0, "R9 R6 counter kept");
    step(1,1,1,1,1,15'h0000, 0,8'h03,0,0,0,0, "R8 end");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule